// File: doc/BRIEF.md
# Flash Boot Sector Scanner

This block runs once after reset and decides how the primary core starts. It captures two boot-strap pins on the first clock edge after reset is released and picks one of three modes: flash boot, serial download over a UART-style link, or serial download over CAN. The serial modes are handled elsewhere. In those modes this block stays idle and keeps the primary core held.

In flash boot the block reads the configuration word at the start of five fixed candidate sectors. It reads them one at a time, in ascending address order, through a synchronous read port that uses a request pulse and a one-cycle data-valid reply. The first sector whose identifier byte holds the boot key is taken. From that sector the block reads the start vector and the integrity-check size. It forms a 4 KB initial page whose base is the vector rounded down, copies the encoding flag into the page descriptor, and then releases the primary core.

If no sector carries the key, the block enters a halted static state with the watchdog enabled. After a programmable number of cycles it starts the whole scan again from the first sector. The secondary core is held in reset in every outcome.

Top module: `boot_scan_top`

## Requirements
- R1: `boot_mode_o` is taken from the pins on the first rising edge after `rst_ni` goes high, as 2'b00 when force=0 (select ignored), 2'b10 for force=1/select=0 (UART serial) and 2'b11 for force=1/select=1 (CAN serial). Later pin changes have no effect.
- R2: In either serial mode no read is issued, and `core_release_o` and `static_mode_o` stay 0.
- R3: In flash mode the configuration words are read at 0x0000_0000, 0x0000_8000, 0x0000_C000, 0x0001_0000 and 0x0001_8000, in that order. Each read is a one-cycle `mem_req_o` pulse, and the next pulse comes the cycle after the `mem_rvalid_i` reply.
- R4: A sector is valid when `mem_rdata_i[23:16]` (the identifier byte) equals 0x5A. Scanning stops at the first valid sector, and later sectors are not read.
- R5: After a valid configuration word the block reads sector base + 0x4 and base + 0x8 and presents them on `start_vector_o` and `check_size_o`.
- R6: `page_vle_o` equals bit 24 of the valid configuration word (1 = variable-length encoding). `page_base_o` equals `start_vector_o[31:12]`.
- R7: `core_release_o` rises one cycle after the reply to the size read. After that, every output holds its value and no further read is issued.
- R8: When all five sectors are invalid, `static_mode_o` and `wdog_en_o` are 1 for exactly RETRY_CYCLES cycles with no read. The scan then restarts with a read at sector 0, and it can boot if a sector has become valid.
- R9: `sec_core_hold_o` is 1 at all times, including during reset.
- R10: During reset every output is 0 except `sec_core_hold_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_force_i | input | 1 | Strap pin: 1 forces serial download |
| boot_sel_i | input | 1 | Strap pin: serial link select (1 = CAN) |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 32 | Read address, valid with the request |
| mem_rvalid_i | input | 1 | One-cycle read reply strobe |
| mem_rdata_i | input | 32 | Read data, valid with the strobe |
| boot_mode_o | output | 2 | Latched boot mode |
| core_release_o | output | 1 | Primary core released |
| page_base_o | output | 20 | Initial page base, address bits 31:12 |
| page_vle_o | output | 1 | Initial page encoding flag |
| start_vector_o | output | 32 | Start vector of the selected sector |
| check_size_o | output | 32 | Integrity-check block size of the selected sector |
| static_mode_o | output | 1 | Halted static state active |
| wdog_en_o | output | 1 | Watchdog enable |
| sec_core_hold_o | output | 1 | Secondary core reset hold |

## Verification
- **Mode (R1):** the mode is due one edge after reset release. The bench samples it at the next falling edge and then changes the pins to show they are ignored.
- **Release (R7):** release is due the cycle after the size reply. A falling-edge monitor records whether `mem_rvalid_i` was high on the sample just before the rising edge of `core_release_o`.
- **Static window (R8):** the static window must last exactly RETRY_CYCLES cycles. The monitor counts the falling-edge samples with `static_mode_o` high and compares that count with the parameter.
- **Read order (R3):** every request address is logged and compared with the list the bench computes from its own sector images, under reply latencies of 1 to 4 cycles.

// File: rtl/boot_scan_pkg.sv
package boot_scan_pkg;
  localparam int NUM_SECTORS = 5;
  localparam int SEC_W       = $clog2(NUM_SECTORS);
  localparam int AW          = 32;
  localparam int DW          = 32;
  localparam int PAGE_SHIFT  = 12;
  localparam int KEY_LSB     = 16;
  localparam int VLE_BIT     = 24;
  localparam logic [7:0] BOOT_KEY = 8'h5A;

  typedef logic [AW-1:0] addr_t;

  localparam addr_t SECTOR_BASE [NUM_SECTORS] = '{
    32'h0000_0000, 32'h0000_8000, 32'h0000_C000, 32'h0001_0000, 32'h0001_8000
  };

  typedef enum logic [1:0] {
    MODE_FLASH = 2'b00,
    MODE_RSVD  = 2'b01,
    MODE_UART  = 2'b10,
    MODE_CAN   = 2'b11
  } boot_mode_e;

  typedef enum logic [1:0] {
    W_CFG  = 2'd0,
    W_VEC  = 2'd1,
    W_SIZE = 2'd2,
    W_NONE = 2'd3
  } word_e;

  typedef enum logic [2:0] {
    ST_WAIT_MODE,
    ST_READ,
    ST_SERIAL,
    ST_STATIC,
    ST_RUN
  } scan_state_e;
endpackage

// File: rtl/boot_mode_latch.sv
module boot_mode_latch
  import boot_scan_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       force_i,
  input  logic       sel_i,
  output boot_mode_e mode_o,
  output logic       valid_o
);
  boot_mode_e mode_q;
  logic       valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_FLASH;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      // select pin only matters when serial boot is forced
      mode_q  <= boot_mode_e'({force_i, force_i & sel_i});
      valid_q <= 1'b1;
    end
  end

  assign mode_o  = mode_q;
  assign valid_o = valid_q;

  assert_mode_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q && $stable(mode_q));

  assert_mode_legal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != MODE_RSVD);
endmodule

// File: rtl/boot_sector_addr.sv
module boot_sector_addr
  import boot_scan_pkg::*;
(
  input  logic [SEC_W-1:0] sec_i,
  input  word_e            word_i,
  output addr_t            addr_o
);
  addr_t hit [NUM_SECTORS];

  for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_sec
    assign hit[g] = (sec_i == SEC_W'(g)) ? SECTOR_BASE[g] : '0;
  end

  always_comb begin
    addr_t acc;
    acc = '0;
    for (int i = 0; i < NUM_SECTORS; i++) acc = acc | hit[i];
    addr_o = acc | (addr_t'(word_i) << 2);
  end
endmodule

// File: rtl/boot_retry_timer.sv
module boot_retry_timer #(
  parameter int unsigned PERIOD = 1_000_000,
  localparam int CW = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CW'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + CW'(1);
  end

  assert_cnt_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(PERIOD));
endmodule

// File: rtl/boot_scan_fsm.sv
module boot_scan_fsm
  import boot_scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  boot_mode_e       mode_i,
  input  logic             mode_valid_i,
  input  logic             retry_done_i,
  input  logic             rvalid_i,
  input  logic [DW-1:0]    rdata_i,
  output logic             req_o,
  output logic [SEC_W-1:0] sec_o,
  output word_e            word_o,
  output logic             static_o,
  output logic             release_o,
  output logic             vle_o,
  output logic [DW-1:0]    vec_o,
  output logic [DW-1:0]    size_o
);
  scan_state_e      state_q;
  logic [SEC_W-1:0] sec_q;
  word_e            word_q;
  logic             req_q, vle_q, rel_q, static_q;
  logic [DW-1:0]    vec_q, size_q;
  logic             key_ok;

  assign key_ok = (rdata_i[KEY_LSB +: 8] == BOOT_KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_WAIT_MODE;
      sec_q    <= '0;
      word_q   <= W_CFG;
      req_q    <= 1'b0;
      vle_q    <= 1'b0;
      vec_q    <= '0;
      size_q   <= '0;
      rel_q    <= 1'b0;
      static_q <= 1'b0;
    end else begin
      req_q <= 1'b0;
      unique case (state_q)
        ST_WAIT_MODE: if (mode_valid_i) begin
          if (mode_i == MODE_FLASH) begin
            sec_q   <= '0;
            word_q  <= W_CFG;
            req_q   <= 1'b1;
            state_q <= ST_READ;
          end else begin
            state_q <= ST_SERIAL;
          end
        end
        ST_READ: if (rvalid_i) begin
          unique case (word_q)
            W_CFG: begin
              if (key_ok) begin
                vle_q  <= rdata_i[VLE_BIT];
                word_q <= W_VEC;
                req_q  <= 1'b1;
              end else if (sec_q == SEC_W'(NUM_SECTORS - 1)) begin
                static_q <= 1'b1;
                state_q  <= ST_STATIC;
              end else begin
                sec_q <= sec_q + SEC_W'(1);
                req_q <= 1'b1;
              end
            end
            W_VEC: begin
              vec_q  <= rdata_i;
              word_q <= W_SIZE;
              req_q  <= 1'b1;
            end
            W_SIZE: begin
              size_q  <= rdata_i;
              rel_q   <= 1'b1;
              word_q  <= W_NONE;
              state_q <= ST_RUN;
            end
            default: ;
          endcase
        end
        ST_STATIC: if (retry_done_i) begin
          static_q <= 1'b0;
          sec_q    <= '0;
          word_q   <= W_CFG;
          req_q    <= 1'b1;
          state_q  <= ST_READ;
        end
        default: ;
      endcase
    end
  end

  assign req_o     = req_q;
  assign sec_o     = sec_q;
  assign word_o    = word_q;
  assign static_o  = static_q;
  assign release_o = rel_q;
  assign vle_o     = vle_q;
  assign vec_o     = vec_q;
  assign size_o    = size_q;

  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  assert_serial_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_valid_i && mode_i != MODE_FLASH) |-> (!req_q && !rel_q && !static_q));

  assert_static_no_req_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    static_q |-> !req_q);

  assert_release_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |=> rel_q && !req_q && $stable(vec_q) && $stable(size_q) && $stable(vle_q));

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rel_q && static_q));
endmodule

// File: rtl/boot_scan_top.sv
module boot_scan_top
  import boot_scan_pkg::*;
#(
  parameter int unsigned RETRY_CYCLES = 1_000_000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     boot_force_i,
  input  logic                     boot_sel_i,
  output logic                     mem_req_o,
  output logic [AW-1:0]            mem_addr_o,
  input  logic                     mem_rvalid_i,
  input  logic [DW-1:0]            mem_rdata_i,
  output logic [1:0]               boot_mode_o,
  output logic                     core_release_o,
  output logic [AW-1:PAGE_SHIFT]   page_base_o,
  output logic                     page_vle_o,
  output logic [AW-1:0]            start_vector_o,
  output logic [DW-1:0]            check_size_o,
  output logic                     static_mode_o,
  output logic                     wdog_en_o,
  output logic                     sec_core_hold_o
);
  boot_mode_e       mode;
  logic             mode_valid, retry_done, static_q;
  logic [SEC_W-1:0] sec;
  word_e            word;
  logic [DW-1:0]    vec;

  boot_mode_latch u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .force_i (boot_force_i),
    .sel_i   (boot_sel_i),
    .mode_o  (mode),
    .valid_o (mode_valid)
  );

  boot_retry_timer #(.PERIOD(RETRY_CYCLES)) u_retry (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (static_q),
    .done_o (retry_done)
  );

  boot_scan_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode),
    .mode_valid_i (mode_valid),
    .retry_done_i (retry_done),
    .rvalid_i     (mem_rvalid_i),
    .rdata_i      (mem_rdata_i),
    .req_o        (mem_req_o),
    .sec_o        (sec),
    .word_o       (word),
    .static_o     (static_q),
    .release_o    (core_release_o),
    .vle_o        (page_vle_o),
    .vec_o        (vec),
    .size_o       (check_size_o)
  );

  boot_sector_addr u_addr (
    .sec_i  (sec),
    .word_i (word),
    .addr_o (mem_addr_o)
  );

  assign boot_mode_o     = mode;
  assign start_vector_o  = vec;
  assign page_base_o     = vec[AW-1:PAGE_SHIFT];
  assign static_mode_o   = static_q;
  assign wdog_en_o       = static_q;
  assign sec_core_hold_o = 1'b1;

  assert_req_in_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00 && mem_addr_o < 32'h0001_8010));
endmodule

// File: tb/boot_scan_top_tb_top.sv
module boot_scan_top_tb_top;
  localparam int RETRY = 40;
  localparam logic [31:0] SEC_BASE [5] = '{
    32'h0000_0000, 32'h0000_8000, 32'h0000_C000, 32'h0001_0000, 32'h0001_8000
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        force_pin = 1'b0, sel_pin = 1'b0;
  logic        mem_req, mem_rvalid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic [1:0]  boot_mode;
  logic        core_release, page_vle, static_mode, wdog_en, sec_hold;
  logic [19:0] page_base;
  logic [31:0] start_vector, check_size;

  always #4 clk = ~clk;

  boot_scan_top #(.RETRY_CYCLES(RETRY)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .boot_force_i(force_pin), .boot_sel_i(sel_pin),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid),
    .mem_rdata_i(mem_rdata), .boot_mode_o(boot_mode), .core_release_o(core_release),
    .page_base_o(page_base), .page_vle_o(page_vle), .start_vector_o(start_vector),
    .check_size_o(check_size), .static_mode_o(static_mode), .wdog_en_o(wdog_en),
    .sec_core_hold_o(sec_hold)
  );

  int errors = 0, total = 0;
  logic [31:0] img [5][3];
  int lat = 1;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    for (int s = 0; s < 5; s++)
      for (int w = 0; w < 3; w++)
        if (a == SEC_BASE[s] + 32'(w * 4)) return img[s][w];
    return 32'hDEAD_BEEF;
  endfunction

  function automatic int first_valid();
    for (int s = 0; s < 5; s++) if (img[s][0][23:16] == 8'h5A) return s;
    return -1;
  endfunction

  // memory model: reply lat cycles after the request edge
  int          pend_cnt = 0;
  logic [31:0] pend_addr = '0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend_cnt > 0) begin
      pend_cnt <= pend_cnt - 1;
      if (pend_cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_word(pend_addr);
      end
    end else if (rst_n && mem_req) begin
      pend_addr <= mem_addr;
      pend_cnt  <= lat;
    end
  end

  // falling-edge monitor
  logic [31:0] req_log [32];
  int          nreq, st_len, last_st_len;
  logic        rel_prev, st_prev, rv_prev, rel_timing_ok, stable_bad, st_req_bad, hold_bad = 1'b0;
  logic [88:0] snap;
  function automatic logic [88:0] outs();
    return {page_base, page_vle, start_vector, check_size, static_mode, boot_mode, core_release};
  endfunction
  always @(negedge clk) begin
    if (!sec_hold) hold_bad = 1'b1;
    if (!rst_n) begin
      nreq = 0; st_len = 0; last_st_len = -1; rel_prev = 0; st_prev = 0; rv_prev = 0;
      rel_timing_ok = 0; stable_bad = 0; st_req_bad = 0; snap = '0;
    end else begin
      if (mem_req) begin
        if (nreq < 32) req_log[nreq] = mem_addr;
        nreq++;
      end
      if (core_release && !rel_prev) begin rel_timing_ok = rv_prev; snap = outs(); end
      else if (core_release && outs() != snap) stable_bad = 1'b1;
      if (static_mode) begin
        st_len++;
        if (mem_req || !wdog_en) st_req_bad = 1'b1;
      end else if (st_prev) begin
        last_st_len = st_len; st_len = 0;
      end
      rel_prev = core_release; st_prev = static_mode; rv_prev = mem_rvalid;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic f, input logic s);
    rst_n = 1'b0; force_pin = f; sel_pin = s;
    repeat (3) @(negedge clk);
    chk(outs() == '0 && !mem_req && !wdog_en && sec_hold, "R10 reset outputs",
        {31'b0, core_release | static_mode | mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(boot_mode == {f, f & s}, "R1 mode latch", 32'(boot_mode), 32'({f, f & s}));
    force_pin = ~f; sel_pin = ~s;  // later pin changes must be ignored
  endtask

  task automatic check_reads(input int k);
    logic [31:0] exp [8];
    int n = 0, bad = 0;
    int last = (k < 0) ? 4 : k;
    for (int s = 0; s <= last; s++) exp[n++] = SEC_BASE[s];
    if (k >= 0) begin exp[n++] = SEC_BASE[k] + 4; exp[n++] = SEC_BASE[k] + 8; end
    chk(nreq >= n, "R3 read count", 32'(nreq), 32'(n));
    for (int i = 0; i < n && i < nreq; i++) if (req_log[i] != exp[i]) bad++;
    chk(bad == 0, "R3/R4 read order", 32'(bad), 32'h0);
  endtask

  task automatic run_flash(input logic s);
    int k = first_valid();
    do_reset(1'b0, s);
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (core_release || static_mode) break;
    end
    repeat (2) @(negedge clk);
    if (k >= 0) begin
      chk(core_release && !static_mode, "R7 release", 32'(core_release), 32'h1);
      chk(start_vector == img[k][1], "R5 vector", start_vector, img[k][1]);
      chk(check_size == img[k][2], "R5 size", check_size, img[k][2]);
      chk(page_base == img[k][1][31:12], "R6 page base", 32'(page_base), 32'(img[k][1][31:12]));
      chk(page_vle == img[k][0][24], "R6 vle", 32'(page_vle), 32'(img[k][0][24]));
      chk(rel_timing_ok, "R7 release timing", 32'(rel_timing_ok), 32'h1);
      check_reads(k);
      repeat (20) @(negedge clk);
      chk(!stable_bad && nreq == k + 3, "R7 hold after release", 32'(nreq), 32'(k + 3));
      chk(boot_mode == 2'b00, "R1 pins ignored", 32'(boot_mode), 32'h0);
    end else begin
      chk(static_mode && wdog_en && !core_release, "R8 static entry", 32'(static_mode), 32'h1);
      check_reads(-1);
      for (int i = 0; i < RETRY + 10; i++) begin
        @(negedge clk);
        if (!static_mode) break;
      end
      @(negedge clk);
      chk(last_st_len == RETRY && !st_req_bad, "R8 static length", 32'(last_st_len), 32'(RETRY));
      chk(nreq >= 6 && req_log[5] == 32'h0, "R8 rescan from sector 0", req_log[5], 32'h0);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int kind);
    logic [31:0] c = $urandom;
    logic [7:0]  key;
    case (kind)
      0: key = 8'h5A;
      1: key = 8'h5A ^ (8'h1 << ($urandom % 8));
      2: begin key = 8'hA5; c[7:0] = 8'h5A; end
      default: begin key = 8'($urandom); if (key == 8'h5A) key = 8'h00; end
    endcase
    c[23:16] = key;
    return c;
  endfunction

  task automatic fill(input int k0, input int kind_bad);
    for (int s = 0; s < 5; s++) begin
      img[s][0] = mk_cfg((s == k0) ? 0 : kind_bad);
      img[s][1] = $urandom;
      img[s][2] = $urandom;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0001));
    fill(-1, 3);
    // R2: serial modes stay idle
    for (int m = 0; m < 2; m++) begin
      do_reset(1'b1, 1'(m));
      repeat (60) @(negedge clk);
      chk(nreq == 0 && !core_release && !static_mode, "R2 serial idle", 32'(nreq), 32'h0);
      chk(boot_mode == {1'b1, 1'(m)}, "R1 serial pins ignored", 32'(boot_mode), 32'({1'b1, 1'(m)}));
    end
    // R6: vector near end of a 4 KB block
    fill(0, 1); img[0][1] = 32'h0000_0FF0; img[0][0][24] = 1'b1; lat = 1;
    run_flash(1'b1);
    // R4: only last sector valid, near-miss keys elsewhere
    fill(4, 1); img[1][0] = mk_cfg(2); lat = 3;
    run_flash(1'b0);
    // R4: two valid sectors, first wins
    fill(1, 3); img[3][0] = mk_cfg(0); lat = 2;
    run_flash(1'b0);
    // R8: no valid sector, then retry
    fill(-1, 1); lat = 2;
    run_flash(1'b0);
    // R8: sector made valid while static, retry boots
    fill(-1, 2); lat = 1;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (static_mode) break; end
    img[2][0] = mk_cfg(0);
    for (int i = 0; i < RETRY + 200; i++) begin @(negedge clk); if (core_release) break; end
    repeat (2) @(negedge clk);
    chk(core_release && start_vector == img[2][1], "R8 retry boot", start_vector, img[2][1]);
    chk(nreq == 10, "R8 retry read count", 32'(nreq), 32'd10);
    // random images
    for (int t = 0; t < 20; t++) begin
      int v = $urandom % 6;
      fill((v == 5) ? -1 : int'(v), 1 + int'($urandom % 3));
      for (int s = 0; s < 5; s++) if ($urandom % 4 == 0) img[s][0] = mk_cfg(0);
      lat = 1 + int'($urandom % 4);
      run_flash(1'($urandom));
    end
    chk(!hold_bad, "R9 secondary hold", 32'(hold_bad), 32'h0);
    $display("  Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end
endmodule